// File: doc/BRIEF.md
# Serial Transceiver with Handshake and In-Band Flow Control

This block is a full-duplex asynchronous serial transceiver with a fixed frame of one start bit, eight data bits sent least significant bit first, no parity and one stop bit. Each direction has two stages: a holding register facing the parallel side and a shift register facing the line. Bit timing comes from an internal divider that turns the system clock into a tick at sixteen times the bit rate. The receiver oversamples at that rate and takes each bit near its centre.

Parallel data moves over valid/ready streams. On the transmit side, a byte is taken on any cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` is high exactly while the transmit holding register is empty. The producer keeps `tx_valid` and `tx_data` steady until the byte is taken. On the receive side, `rx_valid` stays high and `rx_data` holds its value until the consumer raises `rx_ready`. The line never waits for the consumer, so a frame that arrives while the holding register is full is dropped and flagged.

Flow control comes in two forms, and either can be enabled on its own. With handshaking enabled, the clear-to-send input gates the start of new frames, and the request-to-send output tells the far end whether the receiver has room. With in-band control enabled, the block reacts to received pause and resume characters and sends them itself when its receive holding register fills and empties. Interrupt and DMA request pins reflect the buffer state, so data can be moved by polling, by interrupt or by a DMA engine.

Top module: `sercom_flow`

## Requirements
- R1: After reset, `txd` is 1, `rts_n` is 0, `rx_valid` is 0, `tx_ready` is 1, `overrun` is 0 and `tx_paused` is 0.
- R2: Each transmitted frame on `txd` is a 0 start bit, then eight data bits starting with bit 0, then a 1 stop bit. Every bit lasts 16 × `baud_div` clock cycles, and a `baud_div` of 0 acts as 1.
- R3: While a frame is being shifted out, a second byte can be accepted into the holding register. The two frames go out back to back, and the held byte stays unchanged until its frame starts.
- R4: A received frame with a valid stop bit is placed on `rx_data` with `rx_valid` = 1. The value stays stable until a cycle where `rx_ready` is 1.
- R5: If a frame completes while `rx_valid` is already 1, the new byte is discarded, the old byte is kept, and `overrun` goes to 1. `overrun` returns to 0 on the next accepted read.
- R6: `rts_n` is 1 while the receive holding register is full and 0 otherwise.
- R7: When `cts_en` is 1 and `cts_n` is 1, no new frame starts. A frame already in progress completes.
- R8: When `xon_en` is 1, a received 0x13 sets `tx_paused` and a received 0x11 clears it. Neither character reaches `rx_data`. While paused, no data frame starts, but a frame already in progress completes.
- R9: When `xon_en` is 1 and the receive holding register becomes full, the transmitter sends 0x13 ahead of any held data. After that byte is read, it sends 0x11.
- R10: When `xon_en` is 0, received 0x11 and 0x13 are ordinary data, `tx_paused` stays 0, and no control character is sent.
- R11: `irq_rx` = `rx_valid` OR `overrun`. `dma_rx_req` = `rx_valid`. `irq_tx` and `dma_tx_req` both equal `tx_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_div | input | DIV_W | Clock cycles per 16x oversample tick |
| cts_en | input | 1 | Enable clear-to-send gating |
| xon_en | input | 1 | Enable in-band pause/resume characters |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmit holding register empty |
| tx_data | input | 8 | Transmit byte |
| rx_valid | output | 1 | Receive holding register full |
| rx_ready | input | 1 | Consumer takes the received byte |
| rx_data | output | 8 | Received byte |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input, idle high |
| cts_n | input | 1 | Clear to send, active low |
| rts_n | output | 1 | Request to send, active low |
| overrun | output | 1 | Receive overrun flag |
| tx_paused | output | 1 | Transmission paused by a received 0x13 |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx | output | 1 | Receive interrupt |
| dma_tx_req | output | 1 | DMA request for a transmit byte |
| dma_rx_req | output | 1 | DMA request for a received byte |

## Verification
The assertions check four things on every cycle:
- a frame never starts after a cycle in which clear-to-send blocked it;
- a data frame never starts while paused;
- neither holding register changes while it waits on its stage or on the consumer;
- `overrun` and the record of a sent 0x13 only change for a legal cause.

The bench's directed scenarios are needed for the line-level behaviour: bit order and bit length, back-to-back frames, dropping the second byte on overrun, filtering of the control characters, and automatic sending of 0x13 and 0x11 in response to buffer occupancy.

// File: rtl/sercom_pkg.sv
package sercom_pkg;
  typedef logic [7:0] byte_t;
  localparam byte_t    CH_PAUSE  = 8'h13;
  localparam byte_t    CH_RESUME = 8'h11;
  localparam logic [3:0] OS_LAST  = 4'd15;
  localparam logic [3:0] OS_MID   = 4'd7;
  localparam logic [3:0] BIT_STOP = 4'd9;
endpackage

// File: rtl/sercom_baudgen.sv
module sercom_baudgen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  assign lim  = (div == '0) ? '0 : div - DIV_W'(1);
  assign tick = (cnt >= lim);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/sercom_tx.sv
module sercom_tx
  import sercom_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  logic  tx_valid,
  input  byte_t tx_data,
  output logic  tx_ready,
  input  logic  cts_ok,
  input  logic  pause,
  input  logic  ctrl_req,
  input  byte_t ctrl_byte,
  output logic  ctrl_ack,
  output logic  txd
);
  logic       hold_full;
  byte_t      hold_data;
  logic       busy;
  logic       cur_ctrl;
  logic [9:0] shreg;
  logic [3:0] os_cnt;
  logic [3:0] bit_idx;
  logic       start_ctrl, start_data, accept;

  assign accept     = tx_valid && !hold_full;
  assign start_ctrl = tick && !busy && cts_ok && ctrl_req;
  assign start_data = tick && !busy && cts_ok && !pause && hold_full && !start_ctrl;
  assign tx_ready   = !hold_full;
  assign ctrl_ack   = start_ctrl;
  assign txd        = busy ? shreg[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_data <= '0;
    end else begin
      hold_full <= (hold_full && !start_data) || accept;
      if (accept) hold_data <= tx_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cur_ctrl <= 1'b0;
      shreg    <= '1;
      os_cnt   <= '0;
      bit_idx  <= '0;
    end else if (start_ctrl || start_data) begin
      busy     <= 1'b1;
      cur_ctrl <= start_ctrl;
      shreg    <= {1'b1, (start_ctrl ? ctrl_byte : hold_data), 1'b0};
      os_cnt   <= '0;
      bit_idx  <= '0;
    end else if (busy && tick) begin
      if (os_cnt == OS_LAST) begin
        os_cnt <= '0;
        shreg  <= {1'b1, shreg[9:1]};
        if (bit_idx == BIT_STOP) busy <= 1'b0;
        else bit_idx <= bit_idx + 4'd1;
      end else begin
        os_cnt <= os_cnt + 4'd1;
      end
    end
  end

  // R7: a frame only begins after a cycle with clear-to-send granted
  a_r7_cts_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cts_ok));
  // R8: a data frame never begins while paused
  a_r8_pause_gate: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !cur_ctrl) |-> $past(!pause));
  // R3: the held byte waits unchanged for its frame
  a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full && !start_data) |=> (hold_full && $stable(hold_data)));
endmodule

// File: rtl/sercom_rx.sv
module sercom_rx
  import sercom_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  logic  rxd,
  input  logic  xon_en,
  input  logic  rx_ready,
  output logic  rx_valid,
  output byte_t rx_data,
  output logic  overrun,
  output logic  pause_seen,
  output logic  resume_seen
);
  logic       rx_m, rx_s;
  logic       busy;
  logic [3:0] os_cnt;
  logic [3:0] bit_idx;
  byte_t      shreg;
  logic       frame_ok, is_pause, is_resume, store, take, room, mid;

  assign mid         = tick && busy && (os_cnt == OS_MID);
  assign frame_ok    = mid && (bit_idx == BIT_STOP) && rx_s;
  assign is_pause    = xon_en && (shreg == CH_PAUSE);
  assign is_resume   = xon_en && (shreg == CH_RESUME);
  assign store       = frame_ok && !is_pause && !is_resume;
  assign take        = rx_valid && rx_ready;
  assign room        = !rx_valid || take;
  assign pause_seen  = frame_ok && is_pause;
  assign resume_seen = frame_ok && is_resume;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      rx_m <= rxd;
      rx_s <= rx_m;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      os_cnt  <= '0;
      bit_idx <= '0;
      shreg   <= '0;
    end else if (tick) begin
      if (!busy) begin
        if (!rx_s) begin
          busy    <= 1'b1;
          os_cnt  <= '0;
          bit_idx <= '0;
        end
      end else if (os_cnt == OS_MID && bit_idx == BIT_STOP) begin
        busy <= 1'b0;
      end else if (os_cnt == OS_MID && bit_idx == 4'd0 && rx_s) begin
        busy <= 1'b0;
      end else begin
        if (os_cnt == OS_MID && bit_idx != 4'd0) shreg <= {rx_s, shreg[7:1]};
        if (os_cnt == OS_LAST) begin
          os_cnt  <= '0;
          bit_idx <= bit_idx + 4'd1;
        end else begin
          os_cnt <= os_cnt + 4'd1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
      overrun  <= 1'b0;
    end else begin
      if (store && room) begin
        rx_valid <= 1'b1;
        rx_data  <= shreg;
      end else if (take) begin
        rx_valid <= 1'b0;
      end
      if (store && !room) overrun <= 1'b1;
      else if (take)      overrun <= 1'b0;
    end
  end

  // R4: an unread byte stays on the output unchanged
  a_r4_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
  // R5: overrun can only rise while a byte was already waiting
  a_r5_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(rx_valid));
endmodule

// File: rtl/sercom_flow.sv
module sercom_flow
  import sercom_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             cts_en,
  input  logic             xon_en,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [7:0]       tx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [7:0]       rx_data,
  output logic             txd,
  input  logic             rxd,
  input  logic             cts_n,
  output logic             rts_n,
  output logic             overrun,
  output logic             tx_paused,
  output logic             irq_tx,
  output logic             irq_rx,
  output logic             dma_tx_req,
  output logic             dma_rx_req
);
  logic  tick;
  logic  pause_seen, resume_seen;
  logic  pause_sent;
  logic  need_pause, need_resume;
  logic  ctrl_req, ctrl_ack, cts_ok;
  byte_t ctrl_byte;

  assign cts_ok      = !cts_en || !cts_n;
  assign need_pause  = xon_en && rx_valid && !pause_sent;
  assign need_resume = pause_sent && !rx_valid;
  assign ctrl_req    = need_pause || need_resume;
  assign ctrl_byte   = need_pause ? CH_PAUSE : CH_RESUME;

  sercom_baudgen #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tick)
  );

  sercom_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .cts_ok(cts_ok), .pause(tx_paused),
    .ctrl_req(ctrl_req), .ctrl_byte(ctrl_byte), .ctrl_ack(ctrl_ack),
    .txd(txd)
  );

  sercom_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .xon_en(xon_en),
    .rx_ready(rx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .overrun(overrun), .pause_seen(pause_seen), .resume_seen(resume_seen)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)           tx_paused <= 1'b0;
    else if (!xon_en)     tx_paused <= 1'b0;
    else if (pause_seen)  tx_paused <= 1'b1;
    else if (resume_seen) tx_paused <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        pause_sent <= 1'b0;
    else if (ctrl_ack) pause_sent <= need_pause;
  end

  assign rts_n      = rx_valid;
  assign irq_rx     = rx_valid || overrun;
  assign dma_rx_req = rx_valid;
  assign irq_tx     = tx_ready;
  assign dma_tx_req = tx_ready;

  // R9: the record of a sent pause character only moves when a control frame starts
  a_r9_pause_record: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pause_sent) |-> $past(ctrl_ack));
endmodule

// File: tb/sercom_flow_tb.sv
module sercom_flow_tb;
  localparam int DIV = 2;
  localparam int BIT = 16 * DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] baud_div = 16'(DIV);
  logic cts_en = 1'b0, xon_en = 1'b0;
  logic tx_valid = 1'b0, rx_ready = 1'b0;
  logic [7:0] tx_data = '0;
  logic rxd = 1'b1, cts_n = 1'b0;
  logic tx_ready, rx_valid, txd, rts_n, overrun, tx_paused;
  logic irq_tx, irq_rx, dma_tx_req, dma_rx_req;
  logic [7:0] rx_data;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  sercom_flow u_dut (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .cts_en(cts_en), .xon_en(xon_en),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .txd(txd), .rxd(rxd), .cts_n(cts_n), .rts_n(rts_n),
    .overrun(overrun), .tx_paused(tx_paused), .irq_tx(irq_tx), .irq_rx(irq_rx),
    .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_rx(input logic [7:0] b);
    @(negedge clk);
    rxd = 1'b0; cyc(BIT);
    for (int i = 0; i < 8; i++) begin rxd = b[i]; cyc(BIT); end
    rxd = 1'b1; cyc(BIT);
  endtask

  task automatic catch_tx(output logic [7:0] b, output logic ok);
    int w;
    logic s;
    w = 0; ok = 1'b0; b = '0;
    @(negedge clk);
    while (txd !== 1'b0 && w < 3000) begin @(negedge clk); w++; end
    if (w >= 3000) return;
    cyc(BIT / 2);
    s = txd;
    for (int i = 0; i < 8; i++) begin cyc(BIT); b[i] = txd; end
    cyc(BIT);
    ok = (s == 1'b0) && (txd == 1'b1);
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1; tx_data = b;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
  endtask

  task automatic line_quiet(input int n, output logic low);
    low = 1'b0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (txd !== 1'b1) low = 1'b1; end
  endtask

  task automatic t_reset();
    chk("R1 txd", txd, 1);
    chk("R1 rts_n", rts_n, 0);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 tx_ready", tx_ready, 1);
    chk("R1 overrun", overrun, 0);
    chk("R1 tx_paused", tx_paused, 0);
    chk("R11 irq_tx", irq_tx, 1);
    chk("R11 dma_tx_req", dma_tx_req, 1);
    chk("R11 irq_rx", irq_rx, 0);
  endtask

  task automatic t_tx_pair();
    logic [7:0] a, b;
    logic oka, okb;
    fork
      begin catch_tx(a, oka); catch_tx(b, okb); end
      begin push(8'hA5); push(8'h3C); chk("R3 holding full", tx_ready, 0); end
    join
    chk("R2 first frame", {oka, a}, {1'b1, 8'hA5});
    chk("R3 second frame", {okb, b}, {1'b1, 8'h3C});
  endtask

  task automatic t_rx();
    drive_rx(8'h5A);
    chk("R4 rx_valid", rx_valid, 1);
    chk("R4 rx_data", rx_data, 8'h5A);
    chk("R6 rts_n full", rts_n, 1);
    chk("R11 irq_rx", irq_rx, 1);
    chk("R11 dma_rx_req", dma_rx_req, 1);
    cyc(50);
    chk("R4 data held", rx_data, 8'h5A);
    pop();
    chk("R4 rx_valid cleared", rx_valid, 0);
    chk("R6 rts_n empty", rts_n, 0);
  endtask

  task automatic t_overrun();
    drive_rx(8'h5A);
    drive_rx(8'h99);
    chk("R5 overrun set", overrun, 1);
    chk("R5 old byte kept", rx_data, 8'h5A);
    pop();
    chk("R5 overrun cleared", overrun, 0);
    chk("R5 second byte dropped", rx_valid, 0);
  endtask

  task automatic t_cts();
    logic [7:0] b;
    logic ok, low;
    cts_en = 1'b1; cts_n = 1'b1;
    push(8'hC3);
    line_quiet(400, low);
    chk("R7 blocked by cts", low, 0);
    fork
      catch_tx(b, ok);
      begin cyc(2); cts_n = 1'b0; end
    join
    chk("R7 sent after cts", {ok, b}, {1'b1, 8'hC3});
    cts_en = 1'b0;
  endtask

  task automatic t_pause();
    logic [7:0] b;
    logic ok, low;
    xon_en = 1'b1;
    drive_rx(8'h13);
    chk("R8 pause not stored", rx_valid, 0);
    chk("R8 paused", tx_paused, 1);
    push(8'h42);
    line_quiet(400, low);
    chk("R8 held while paused", low, 0);
    fork
      drive_rx(8'h11);
      catch_tx(b, ok);
    join
    chk("R8 resumed frame", {ok, b}, {1'b1, 8'h42});
    chk("R8 resume not stored", rx_valid, 0);
    chk("R8 unpaused", tx_paused, 0);
  endtask

  task automatic t_auto_flow();
    logic [7:0] b;
    logic ok;
    fork
      drive_rx(8'h77);
      catch_tx(b, ok);
    join
    chk("R9 pause sent", {ok, b}, {1'b1, 8'h13});
    chk("R9 byte kept", rx_data, 8'h77);
    fork
      pop();
      catch_tx(b, ok);
    join
    chk("R9 resume sent", {ok, b}, {1'b1, 8'h11});
    xon_en = 1'b0;
  endtask

  task automatic t_plain_chars();
    logic low;
    drive_rx(8'h13);
    chk("R10 char stored", {rx_valid, rx_data}, {1'b1, 8'h13});
    chk("R10 no pause", tx_paused, 0);
    line_quiet(400, low);
    chk("R10 no control sent", low, 0);
    pop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    cyc(4);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_tx_pair();
    t_rx();
    t_overrun();
    t_cts();
    t_pause();
    t_auto_flow();
    t_plain_chars();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule